// File: doc/BRIEF.md
# On-Hook Caller Data Session Sequencer

This block is a host-side controller for a tone-shift data receiver that carries one on-hook data session tied to ringing. It keeps the receiver unpowered while the first ring burst is present. When the ring ends it powers the receiver up. After a start-up delay it enables demodulation and waits a bounded time for carrier. Once carrier arrives it reports which protocol phase is in progress: the alternating-bit seizure, then the steady-mark interval, then the data. When carrier drops it powers the receiver down.

All timing is counted in whole ticks of a one-millisecond strobe, and every limit is a parameter. Three sticky flags report faults. The first is no carrier within the window. The second is carrier lasting past the total budget for seizure, mark and data. The third is a new ring that arrives before the required quiet gap after carrier ends. The flags stay set until the next session's receiver power-up.

Top module: `onhook_seq`

## Requirements
- R1: While reset is held and just after it, `rxPwrEn`, `fskEn`, `sessionActive` and all three error flags are low, and `phase` is 0.
- R2: While `ringDet` is high, `rxPwrEn` stays low, and `carrierDet` has no effect on `phase`. On the first clock edge that samples `ringDet` low after a ring, `rxPwrEn` and `sessionActive` go high with `fskEn` still low.
- R3: `fskEn` goes high on the edge that samples the `PWRUP_MS`-th tick after power-up, and not before.
- R4: If `carrierDet` has not been seen high by the `CD_WIN_MS`-th tick after `fskEn` rose, `errTimeout` is set on that tick's edge. `rxPwrEn`, `fskEn` and `sessionActive` then go low.
- R5: `phase` encodes 0 = none, 1 = seizure, 2 = mark, 3 = data. On the edge after `carrierDet` is first sampled high while waiting, it becomes 1. It becomes 2 on the `SEIZE_MS`-th tick and 3 on the `SEIZE_MS+MARK_MS`-th tick, both counted from carrier arrival.
- R6: If carrier stays high for `BUDGET_MS` ticks counted from its arrival, `errBudget` is set on that tick's edge. `rxPwrEn`, `fskEn`, `sessionActive` go low and `phase` returns to 0. Shorter carrier never sets `errBudget`.
- R7: On the edge that samples `carrierDet` low during seizure, mark or data, `rxPwrEn` and `fskEn` go low and `phase` returns to 0. `sessionActive` stays high for the quiet-gap interval.
- R8: During the quiet gap, a ring seen before `GUARD_MS` ticks have passed sets `errEarlyRing`. At the `GUARD_MS`-th tick `sessionActive` falls, and a later ring sets no flag.
- R9: Error flags remain set through the following idle and ring periods. They clear on the edge that powers up the receiver for the next session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msTick | input | 1 | One-cycle strobe once per millisecond |
| ringDet | input | 1 | Ring burst present |
| carrierDet | input | 1 | Carrier detect from the demodulator |
| rxPwrEn | output | 1 | Receiver power enable |
| fskEn | output | 1 | Demodulator enable |
| sessionActive | output | 1 | Session in progress, including the quiet gap |
| phase | output | 2 | 0 none, 1 seizure, 2 mark, 3 data |
| errTimeout | output | 1 | Sticky: no carrier within the window |
| errBudget | output | 1 | Sticky: carrier exceeded the total budget |
| errEarlyRing | output | 1 | Sticky: ring inside the quiet gap |

## Verification
The assertions assume a few things about the inputs. `msTick` is a single-cycle pulse, never two in a row. A ring is held for at least two clocks before it falls. Ring and carrier edges never share a cycle with a tick. The stimulus meets all of these by driving inputs only on falling clock edges. It places each tick as a one-cycle pulse followed by an idle cycle, and it changes ring and carrier only in cycles with no tick. A reduced parameter set lets the sweeps step carrier arrival, carrier length and ring offset through every tick position up to and just past each limit.

// File: rtl/onhook_seq_pkg.sv
package onhook_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RING,
    S_PWRUP,
    S_WAITCD,
    S_SEIZE,
    S_MARK,
    S_DATA,
    S_GUARD
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrPhase;
    logic clrSess;
    logic cntSess;
    logic setTimeout;
    logic setBudget;
    logic setEarly;
    logic clrErr;
  } seqStrb_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/onhook_seq_dp.sv
module onhook_seq_dp
  import onhook_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BUDGET_MS = 3700
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  seqStrb_t         strb,
  output logic [CNT_W-1:0] phaseCnt,
  output logic [CNT_W-1:0] sessCnt,
  output logic             errTimeout,
  output logic             errBudget,
  output logic             errEarlyRing
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Ticks spent in the current state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strb.clrPhase) begin
      phaseCnt <= '0;
    end else if (msTick && phaseCnt != CNT_MAX) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // Ticks since carrier arrival
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessCnt <= '0;
    end else if (strb.clrSess) begin
      sessCnt <= '0;
    end else if (strb.cntSess && msTick && sessCnt != CNT_MAX) begin
      sessCnt <= sessCnt + 1'b1;
    end
  end

  // Sticky fault flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errTimeout   <= 1'b0;
      errBudget    <= 1'b0;
      errEarlyRing <= 1'b0;
    end else if (strb.clrErr) begin
      errTimeout   <= 1'b0;
      errBudget    <= 1'b0;
      errEarlyRing <= 1'b0;
    end else begin
      if (strb.setTimeout) errTimeout   <= 1'b1;
      if (strb.setBudget)  errBudget    <= 1'b1;
      if (strb.setEarly)   errEarlyRing <= 1'b1;
    end
  end

  p_sess_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    sessCnt <= CNT_W'(BUDGET_MS));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errTimeout || errBudget || errEarlyRing) && !strb.clrErr
      |=> (errTimeout || errBudget || errEarlyRing));

endmodule

// File: rtl/onhook_seq_ctrl.sv
module onhook_seq_ctrl
  import onhook_seq_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int PWRUP_MS  = 20,
  parameter int CD_WIN_MS = 600,
  parameter int SEIZE_MS  = 250,
  parameter int MARK_MS   = 150,
  parameter int BUDGET_MS = 3700,
  parameter int GUARD_MS  = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             ringDet,
  input  logic             carrierDet,
  input  logic [CNT_W-1:0] phaseCnt,
  input  logic [CNT_W-1:0] sessCnt,
  output seqStrb_t         strb,
  output logic             rxPwrEn,
  output logic             fskEn,
  output logic             sessionActive,
  output logic [1:0]       phase
);

  localparam logic [CNT_W-1:0] PW_END = CNT_W'(PWRUP_MS - 1);
  localparam logic [CNT_W-1:0] CW_END = CNT_W'(CD_WIN_MS - 1);
  localparam logic [CNT_W-1:0] SZ_END = CNT_W'(SEIZE_MS - 1);
  localparam logic [CNT_W-1:0] MK_END = CNT_W'(MARK_MS - 1);
  localparam logic [CNT_W-1:0] BG_END = CNT_W'(BUDGET_MS - 1);
  localparam logic [CNT_W-1:0] GD_END = CNT_W'(GUARD_MS - 1);

  seqState_t st, nxt;
  logic      inCarrier;

  assign inCarrier = (st == S_SEIZE) || (st == S_MARK) || (st == S_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt             = st;
    strb            = '0;
    strb.cntSess    = inCarrier;
    case (st)
      S_IDLE:   if (ringDet) nxt = S_RING;
      S_RING: begin
        if (!ringDet) begin
          nxt         = S_PWRUP;
          strb.clrErr = 1'b1;
        end
      end
      S_PWRUP:  if (msTick && phaseCnt == PW_END) nxt = S_WAITCD;
      S_WAITCD: begin
        if (carrierDet) begin
          nxt          = S_SEIZE;
          strb.clrSess = 1'b1;
        end else if (msTick && phaseCnt == CW_END) begin
          nxt             = S_IDLE;
          strb.setTimeout = 1'b1;
        end
      end
      S_SEIZE, S_MARK, S_DATA: begin
        if (!carrierDet) begin
          nxt = S_GUARD;
        end else if (msTick && sessCnt == BG_END) begin
          nxt            = S_IDLE;
          strb.setBudget = 1'b1;
        end else if (st == S_SEIZE && msTick && phaseCnt == SZ_END) begin
          nxt = S_MARK;
        end else if (st == S_MARK && msTick && phaseCnt == MK_END) begin
          nxt = S_DATA;
        end
      end
      S_GUARD: begin
        if (ringDet) begin
          nxt           = S_IDLE;
          strb.setEarly = 1'b1;
        end else if (msTick && phaseCnt == GD_END) begin
          nxt = S_IDLE;
        end
      end
      default:  nxt = S_IDLE;
    endcase
    strb.clrPhase = (nxt != st);
  end

  assign rxPwrEn       = (st == S_PWRUP) || (st == S_WAITCD) || inCarrier;
  assign fskEn         = (st == S_WAITCD) || inCarrier;
  assign sessionActive = rxPwrEn || (st == S_GUARD);

  always_comb begin
    case (st)
      S_SEIZE: phase = 2'd1;
      S_MARK:  phase = 2'd2;
      S_DATA:  phase = 2'd3;
      default: phase = 2'd0;
    endcase
  end

  // Power comes on only right after a ring has ended
  p_pwr_after_ring_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxPwrEn) |-> !$past(ringDet) && $past(ringDet, 2));

  // Phase code only ever steps forward by one, or drops to none
  p_phase_forward_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) && (phase != 2'd0) |-> phase == $past(phase) + 2'd1);

  // Carrier loss during a session powers the receiver down next edge
  p_drop_pwrdn_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierDet) && (phase != 2'd0) |=> !rxPwrEn && !fskEn);

endmodule

// File: rtl/onhook_seq.sv
module onhook_seq
  import onhook_seq_pkg::*;
#(
  parameter int PWRUP_MS  = 20,
  parameter int CD_WIN_MS = 600,
  parameter int SEIZE_MS  = 250,
  parameter int MARK_MS   = 150,
  parameter int BUDGET_MS = 3700,
  parameter int GUARD_MS  = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       ringDet,
  input  logic       carrierDet,
  output logic       rxPwrEn,
  output logic       fskEn,
  output logic       sessionActive,
  output logic [1:0] phase,
  output logic       errTimeout,
  output logic       errBudget,
  output logic       errEarlyRing
);

  localparam int MAX_LIM = maxOf(maxOf(maxOf(PWRUP_MS, CD_WIN_MS), maxOf(SEIZE_MS, MARK_MS)),
                                 maxOf(BUDGET_MS, GUARD_MS));
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  seqStrb_t         strb;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] sessCnt;

  onhook_seq_ctrl #(
    .CNT_W(CNT_W), .PWRUP_MS(PWRUP_MS), .CD_WIN_MS(CD_WIN_MS), .SEIZE_MS(SEIZE_MS),
    .MARK_MS(MARK_MS), .BUDGET_MS(BUDGET_MS), .GUARD_MS(GUARD_MS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ringDet(ringDet), .carrierDet(carrierDet),
    .phaseCnt(phaseCnt), .sessCnt(sessCnt), .strb(strb), .rxPwrEn(rxPwrEn),
    .fskEn(fskEn), .sessionActive(sessionActive), .phase(phase)
  );

  onhook_seq_dp #(
    .CNT_W(CNT_W), .BUDGET_MS(BUDGET_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .strb(strb), .phaseCnt(phaseCnt),
    .sessCnt(sessCnt), .errTimeout(errTimeout), .errBudget(errBudget),
    .errEarlyRing(errEarlyRing)
  );

  // A carrier timeout is only raised while listening with no carrier present
  p_timeout_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errTimeout) |-> $past(fskEn) && !$past(carrierDet) && !fskEn);

  // Demodulator is never enabled without receiver power
  p_fsk_powered_r3: assert property (@(posedge clk) disable iff (!rstN)
    fskEn |-> rxPwrEn);

endmodule

// File: tb/onhook_seq_tb.sv
module onhook_seq_tb;

  localparam int PW = 2;
  localparam int CW = 6;
  localparam int SZ = 3;
  localparam int MK = 2;
  localparam int BG = 12;
  localparam int GD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0;
  logic ringDet = 1'b0;
  logic carrierDet = 1'b0;
  logic rxPwrEn, fskEn, sessionActive, errTimeout, errBudget, errEarlyRing;
  logic [1:0] phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  onhook_seq #(
    .PWRUP_MS(PW), .CD_WIN_MS(CW), .SEIZE_MS(SZ), .MARK_MS(MK),
    .BUDGET_MS(BG), .GUARD_MS(GD)
  ) u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .ringDet(ringDet), .carrierDet(carrierDet),
    .rxPwrEn(rxPwrEn), .fskEn(fskEn), .sessionActive(sessionActive), .phase(phase),
    .errTimeout(errTimeout), .errBudget(errBudget), .errEarlyRing(errEarlyRing)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doMs(input int n);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      step();
      msTick = 1'b0;
      step();
    end
  endtask

  task automatic startSession();
    ringDet = 1'b1;
    step();
    step();
    ringDet = 1'b0;
    step();
    doMs(PW);
  endtask

  task automatic goIdle();
    ringDet = 1'b0;
    carrierDet = 1'b0;
    doMs(PW + CW + GD + 2);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values
    chk("R1 rxPwrEn in reset", rxPwrEn, 0);
    step();
    rstN = 1'b1;
    step();
    chk("R1 rxPwrEn", rxPwrEn, 0);
    chk("R1 fskEn", fskEn, 0);
    chk("R1 sessionActive", sessionActive, 0);
    chk("R1 phase", phase, 0);
    chk("R1 flags", {errTimeout, errBudget, errEarlyRing}, 0);

    // R2: ring keeps receiver off, carrier during ring ignored
    ringDet = 1'b1;
    carrierDet = 1'b1;
    step();
    step();
    doMs(2);
    chk("R2 rxPwrEn during ring", rxPwrEn, 0);
    chk("R2 phase during ring", phase, 0);
    carrierDet = 1'b0;
    ringDet = 1'b0;
    step();
    chk("R2 rxPwrEn after ring", rxPwrEn, 1);
    chk("R2 sessionActive after ring", sessionActive, 1);
    chk("R2 fskEn after ring", fskEn, 0);
    // R3: demodulator enable after power-up ticks
    doMs(PW - 1);
    chk("R3 fskEn early", fskEn, 0);
    doMs(1);
    chk("R3 fskEn on time", fskEn, 1);
    goIdle();

    // R4/R5: carrier arrival swept across the window
    for (int k = 0; k <= CW; k++) begin
      startSession();
      doMs(k);
      if (k == CW) begin
        chk("R4 errTimeout", errTimeout, 1);
        chk("R4 rxPwrEn off", rxPwrEn, 0);
        chk("R4 fskEn off", fskEn, 0);
        chk("R4 sessionActive off", sessionActive, 0);
      end else begin
        chk("R4 no timeout yet", errTimeout, 0);
        chk("R4 fskEn held", fskEn, 1);
        carrierDet = 1'b1;
        step();
        chk("R5 seizure on arrival", phase, 1);
      end
      goIdle();
    end

    // R9: timeout flag survives idle and ring, clears at power-up
    chk("R9 flag held in idle", errTimeout, 1);
    ringDet = 1'b1;
    step();
    step();
    chk("R9 flag held in ring", errTimeout, 1);
    ringDet = 1'b0;
    step();
    chk("R9 flag cleared at power-up", errTimeout, 0);
    goIdle();

    // R5: phase progression per tick
    startSession();
    carrierDet = 1'b1;
    step();
    for (int t = 1; t <= SZ + MK + 2; t++) begin
      doMs(1);
      chk("R5 phase", phase, (t < SZ) ? 1 : (t < SZ + MK) ? 2 : 3);
    end
    goIdle();

    // R6/R7: carrier length swept up to the budget
    for (int l = 1; l <= BG; l++) begin
      startSession();
      carrierDet = 1'b1;
      step();
      doMs(l);
      if (l == BG) begin
        chk("R6 errBudget", errBudget, 1);
        chk("R6 rxPwrEn off", rxPwrEn, 0);
        chk("R6 sessionActive off", sessionActive, 0);
        chk("R6 phase none", phase, 0);
      end else begin
        chk("R6 no budget error", errBudget, 0);
        chk("R6 still powered", rxPwrEn, 1);
        carrierDet = 1'b0;
        step();
        chk("R7 rxPwrEn off", rxPwrEn, 0);
        chk("R7 fskEn off", fskEn, 0);
        chk("R7 phase none", phase, 0);
        chk("R7 sessionActive in gap", sessionActive, 1);
      end
      goIdle();
    end

    // R8: second ring swept across the quiet gap
    for (int g = 0; g <= GD; g++) begin
      startSession();
      carrierDet = 1'b1;
      step();
      doMs(1);
      carrierDet = 1'b0;
      step();
      doMs(g);
      chk("R8 gap active", sessionActive, (g < GD) ? 1 : 0);
      ringDet = 1'b1;
      step();
      chk("R8 early ring flag", errEarlyRing, (g < GD) ? 1 : 0);
      if (g < GD) begin
        // R9: flag survives the ongoing ring
        step();
        step();
        chk("R9 early flag held", errEarlyRing, 1);
        ringDet = 1'b0;
        step();
        chk("R9 early flag cleared", errEarlyRing, 0);
      end
      goIdle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule